// File: doc/BRIEF.md
# Byte ALU with Registered Flag Byte

This block is the arithmetic and logic datapath of a small 8-bit processor core. The instruction decoder presents an operation code, the accumulator value, a second byte operand and the current flag byte. For the register-pair add it also presents two 16-bit words. On a clock edge where `op_valid` is high, the block registers three things: the byte result, a one-cycle write strobe telling the register file whether to store that result, and the next flag byte. The register-pair add produces its own registered 16-bit sum and strobe.

Each operation class has its own rule for which flags it rewrites. Every flag that an operation does not touch is copied from `flags_in`. The flag byte always has a fixed shape: one constant-one bit and two constant-zero bits. Decimal adjust is built as two nibble corrections in sequence, and the first correction can feed the second within the same operation. Instruction decode, the register file and memory access sit outside the block.

Top module: `byte_alu`

## Requirements
- R1: Operation codes on `op_code` are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, XOR=5, OR=6, CMP=7, INC=8, DEC=9, RLC=10, RRC=11, RAL=12, RAR=13, CMA=14, STC=15, CMC=16, DAA=17, DAD=18. Results appear on the outputs one clock after the edge that samples `op_valid`, and operations may be issued back to back.
- R2: In `flags_q`, bit 7 is sign, bit 6 is zero, bit 4 is auxiliary carry, bit 2 is parity and bit 0 is carry. Bit 1 is always 1, and bits 3 and 5 are always 0. While reset is active, `result_q`=0, `wide_q`=0, both strobes are 0 and `flags_q`=8'h02.
- R3: ADD, ADC, SUB and SBB compute accumulator ± operand. ADC adds one more, and SBB subtracts one more, when carry (bit 0 of `flags_in`) is 1. The byte result is written. Carry becomes bit 8 of the 9-bit result, which is the borrow for subtraction. Auxiliary carry is cleared. Sign, zero and parity follow the result.
- R4: AND, XOR and OR write the bitwise result, clear carry and auxiliary carry, and set sign, zero and parity from the result.
- R5: CMP sets flags as SUB would, but raises no write strobe and leaves `result_q` unchanged.
- R6: INC and DEC write the operand plus or minus one, wrapping modulo 256. They update sign, zero and parity only, and keep carry and auxiliary carry from `flags_in`.
- R7: RLC moves accumulator bit 7 into both carry and result bit 0. RRC moves bit 0 into both carry and bit 7. RAL shifts the old carry into bit 0 and bit 7 into carry. RAR shifts the old carry into bit 7 and bit 0 into carry. Other flags are kept.
- R8: CMA writes the inverted accumulator and keeps every flag. STC sets carry and CMC inverts carry; neither writes the result, and both keep the other flags.
- R9: DAA corrects in two steps. If the low nibble exceeds 9 or auxiliary carry is 1, 6 is added to the low nibble and auxiliary carry takes that nibble's carry-out. Then, if the high nibble exceeds 9 or the auxiliary carry resulting from step one is 1, 6 plus that auxiliary carry is added to the high nibble and carry takes its carry-out; otherwise carry is 0. Sign, zero and parity follow the result.
- R10: DAD places `pair_a_in`+`pair_b_in` (mod 65536) on `wide_q` with `wide_we_q` high for one cycle. Carry takes bit 16 of the sum, and every other flag is copied from `flags_in`. The byte result is not written.
- R11: Codes 19 to 31 write nothing and return `flags_in` with only the fixed bits forced. A cycle with `op_valid` low keeps `result_q`, `wide_q` and `flags_q` and drops both strobes.
- R12: Parity is 1 when the 8-bit result holds an even number of one bits, and 0 when the count is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation is issued this cycle |
| op_code | input | 5 | Operation code (R1) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand; the source for INC/DEC |
| flags_in | input | 8 | Current flag byte |
| pair_a_in | input | 16 | First register-pair word for DAD |
| pair_b_in | input | 16 | Second register-pair word for DAD |
| result_q | output | 8 | Registered byte result |
| result_we_q | output | 1 | One-cycle strobe: store `result_q` |
| wide_q | output | 16 | Registered 16-bit sum of DAD |
| wide_we_q | output | 1 | One-cycle strobe: store `wide_q` |
| flags_q | output | 8 | Registered next flag byte |

## Verification
Two things can land in one operation. In decimal adjust, the low-nibble correction raises auxiliary carry, and that carry then both triggers and enlarges the high-nibble correction. Separately, every operation's selective flag update has to merge with the untouched bits passed through from `flags_in`. The bench provokes the first case with accumulator values such as 8'h9B and with auxiliary carry driven in, and the second by feeding flag bytes of all ones and all zeros. A behavioural model computes the full expected flag byte and strobes for each issued operation, and the bench compares them on the following clock across directed and random operands, codes and idle cycles.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int BYTE_W = 8;
  localparam int PAIR_W = 16;
  localparam int OP_W   = 5;
  localparam int NIB_W  = BYTE_W / 2;

  // flag byte bit positions
  localparam int FLG_CY  = 0;
  localparam int FLG_ONE = 1;
  localparam int FLG_PAR = 2;
  localparam int FLG_Z3  = 3;
  localparam int FLG_AUX = 4;
  localparam int FLG_Z5  = 5;
  localparam int FLG_ZER = 6;
  localparam int FLG_SGN = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC = 5'd16, OP_DAA = 5'd17, OP_DAD = 5'd18
  } alu_op_e;

  // what one execution unit asks of the flag merge
  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              wr;
    logic              cy_set;
    logic              cy_val;
    logic              ac_set;
    logic              ac_val;
    logic              szp_set;
  } unit_out_t;

  function automatic logic even_ones(input logic [BYTE_W-1:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub
  import byte_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cy_i,
  output unit_out_t         out_o
);

  localparam int EXT_W = BYTE_W + 1;

  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [EXT_W-1:0] ext_c;
  logic [EXT_W-1:0] sum9;

  assign ext_a = {1'b0, a_i};
  assign ext_b = {1'b0, b_i};
  assign ext_c = {{BYTE_W{1'b0}}, cy_i};

  always_comb begin
    out_o = '0;
    sum9  = '0;
    case (op_i)
      OP_ADD: sum9 = ext_a + ext_b;
      OP_ADC: sum9 = ext_a + ext_b + ext_c;
      OP_SUB, OP_CMP: sum9 = ext_a - ext_b;
      OP_SBB: sum9 = ext_a - ext_b - ext_c;
      OP_INC: sum9 = ext_b + EXT_W'(1);
      OP_DEC: sum9 = ext_b - EXT_W'(1);
      default: sum9 = '0;
    endcase
    out_o.res = sum9[BYTE_W-1:0];
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        out_o.wr      = (op_i != OP_CMP);
        out_o.cy_set  = 1'b1;
        out_o.cy_val  = sum9[BYTE_W];
        out_o.ac_set  = 1'b1;
        out_o.ac_val  = 1'b0;
        out_o.szp_set = 1'b1;
      end
      OP_INC, OP_DEC: begin
        out_o.wr      = 1'b1;
        out_o.szp_set = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_bitops.sv
module byte_alu_bitops
  import byte_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              cy_i,
  output unit_out_t         out_o
);

  localparam int MSB = BYTE_W - 1;

  always_comb begin
    out_o = '0;
    case (op_i)
      OP_AND, OP_XOR, OP_OR: begin
        case (op_i)
          OP_AND:  out_o.res = a_i & b_i;
          OP_XOR:  out_o.res = a_i ^ b_i;
          default: out_o.res = a_i | b_i;
        endcase
        out_o.wr      = 1'b1;
        out_o.cy_set  = 1'b1;
        out_o.cy_val  = 1'b0;
        out_o.ac_set  = 1'b1;
        out_o.ac_val  = 1'b0;
        out_o.szp_set = 1'b1;
      end
      OP_RLC: begin
        out_o.res    = {a_i[MSB-1:0], a_i[MSB]};
        out_o.wr     = 1'b1;
        out_o.cy_set = 1'b1;
        out_o.cy_val = a_i[MSB];
      end
      OP_RRC: begin
        out_o.res    = {a_i[0], a_i[MSB:1]};
        out_o.wr     = 1'b1;
        out_o.cy_set = 1'b1;
        out_o.cy_val = a_i[0];
      end
      OP_RAL: begin
        out_o.res    = {a_i[MSB-1:0], cy_i};
        out_o.wr     = 1'b1;
        out_o.cy_set = 1'b1;
        out_o.cy_val = a_i[MSB];
      end
      OP_RAR: begin
        out_o.res    = {cy_i, a_i[MSB:1]};
        out_o.wr     = 1'b1;
        out_o.cy_set = 1'b1;
        out_o.cy_val = a_i[0];
      end
      OP_CMA: begin
        out_o.res = ~a_i;
        out_o.wr  = 1'b1;
      end
      OP_STC: begin
        out_o.cy_set = 1'b1;
        out_o.cy_val = 1'b1;
      end
      OP_CMC: begin
        out_o.cy_set = 1'b1;
        out_o.cy_val = ~cy_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_decadj.sv
module byte_alu_decadj
  import byte_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic              ac_i,
  output unit_out_t         out_o
);

  localparam int          DIG_W   = NIB_W + 1;
  localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);
  localparam logic [DIG_W-1:0] DIG_FIX = DIG_W'(6);

  logic [BYTE_W-1:0] mid;
  logic [DIG_W-1:0]  lo_sum;
  logic [DIG_W-1:0]  hi_sum;
  logic              ac_mid;

  always_comb begin
    // step one: low digit
    mid    = a_i;
    ac_mid = ac_i;
    lo_sum = {1'b0, a_i[NIB_W-1:0]};
    if ((a_i[NIB_W-1:0] > DIG_MAX) || ac_i) begin
      lo_sum             = {1'b0, a_i[NIB_W-1:0]} + DIG_FIX;
      mid[NIB_W-1:0]     = lo_sum[NIB_W-1:0];
      ac_mid             = lo_sum[NIB_W];
    end
    // step two: high digit, fed by the carry of step one
    hi_sum = {1'b0, mid[BYTE_W-1:NIB_W]};
    if ((mid[BYTE_W-1:NIB_W] > DIG_MAX) || ac_mid) begin
      hi_sum               = {1'b0, mid[BYTE_W-1:NIB_W]} + DIG_FIX + {{NIB_W{1'b0}}, ac_mid};
      mid[BYTE_W-1:NIB_W]  = hi_sum[NIB_W-1:0];
    end
    out_o         = '0;
    out_o.res     = mid;
    out_o.wr      = 1'b1;
    out_o.cy_set  = 1'b1;
    out_o.cy_val  = hi_sum[NIB_W];
    out_o.ac_set  = 1'b1;
    out_o.ac_val  = ac_mid;
    out_o.szp_set = 1'b1;
  end

endmodule

// File: rtl/byte_alu_pairadd.sv
module byte_alu_pairadd #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  logic [WIDTH:0] full;

  assign full    = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o   = full[WIDTH-1:0];
  assign carry_o = full[WIDTH];

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0] opnd_in,
  input  logic [BYTE_W-1:0] flags_in,
  input  logic [PAIR_W-1:0] pair_a_in,
  input  logic [PAIR_W-1:0] pair_b_in,
  output logic [BYTE_W-1:0] result_q,
  output logic              result_we_q,
  output logic [PAIR_W-1:0] wide_q,
  output logic              wide_we_q,
  output logic [BYTE_W-1:0] flags_q
);

  localparam logic [BYTE_W-1:0] FLAGS_RST = BYTE_W'(1) << FLG_ONE;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  alu_op_e op_e;
  assign op_e = alu_op_e'(op_code);

  unit_out_t as_out, bo_out, da_out, pa_out, sel;
  logic [PAIR_W-1:0] pair_sum;
  logic              pair_cy;
  logic              is_pair;

  byte_alu_addsub u_addsub (
    .op_i (op_e), .a_i (acc_in), .b_i (opnd_in),
    .cy_i (flags_in[FLG_CY]), .out_o (as_out)
  );

  byte_alu_bitops u_bitops (
    .op_i (op_e), .a_i (acc_in), .b_i (opnd_in),
    .cy_i (flags_in[FLG_CY]), .out_o (bo_out)
  );

  byte_alu_decadj u_decadj (
    .a_i (acc_in), .ac_i (flags_in[FLG_AUX]), .out_o (da_out)
  );

  byte_alu_pairadd #(.WIDTH(PAIR_W)) u_pairadd (
    .a_i (pair_a_in), .b_i (pair_b_in), .sum_o (pair_sum), .carry_o (pair_cy)
  );

  assign is_pair = (op_e == OP_DAD);

  always_comb begin
    pa_out        = '0;
    pa_out.cy_set = 1'b1;
    pa_out.cy_val = pair_cy;
  end

  // pick the unit that owns the code
  always_comb begin
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_INC, OP_DEC: sel = as_out;
      OP_AND, OP_XOR, OP_OR, OP_RLC, OP_RRC, OP_RAL, OP_RAR,
      OP_CMA, OP_STC, OP_CMC:                                sel = bo_out;
      OP_DAA:                                                sel = da_out;
      OP_DAD:                                                sel = pa_out;
      default:                                               sel = '0;
    endcase
  end

  // flag merge and next state
  logic [BYTE_W-1:0] flags_mrg;
  logic [BYTE_W-1:0] result_d;
  logic              result_we_d;
  logic [PAIR_W-1:0] wide_d;
  logic              wide_we_d;
  logic [BYTE_W-1:0] flags_d;

  always_comb begin
    flags_mrg = flags_in;
    if (sel.szp_set) begin
      flags_mrg[FLG_SGN] = sel.res[BYTE_W-1];
      flags_mrg[FLG_ZER] = (sel.res == '0);
      flags_mrg[FLG_PAR] = even_ones(sel.res);
    end
    if (sel.cy_set) flags_mrg[FLG_CY]  = sel.cy_val;
    if (sel.ac_set) flags_mrg[FLG_AUX] = sel.ac_val;
    flags_mrg[FLG_ONE] = 1'b1;
    flags_mrg[FLG_Z3]  = 1'b0;
    flags_mrg[FLG_Z5]  = 1'b0;

    result_d    = result_q;
    wide_d      = wide_q;
    flags_d     = flags_q;
    result_we_d = 1'b0;
    wide_we_d   = 1'b0;
    if (op_valid) begin
      flags_d     = flags_mrg;
      result_we_d = sel.wr;
      wide_we_d   = is_pair;
      if (sel.wr)  result_d = sel.res;
      if (is_pair) wide_d   = pair_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      result_q    <= '0;
      result_we_q <= 1'b0;
      wide_q      <= '0;
      wide_we_q   <= 1'b0;
      flags_q     <= FLAGS_RST;
    end else begin
      result_q    <= result_d;
      result_we_q <= result_we_d;
      wide_q      <= wide_d;
      wide_we_q   <= wide_we_d;
      flags_q     <= flags_d;
    end
  end

  // R4: logic ops clear both carries
  a_r4_logic_clears_carries: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && (op_e == OP_AND || op_e == OP_XOR || op_e == OP_OR))
      |=> (!flags_q[FLG_CY] && !flags_q[FLG_AUX] && result_we_q));

  // R5: compare never writes the byte result
  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_e == OP_CMP) |=> (!result_we_q && $stable(result_q)));

  // R6: increment and decrement keep carry and auxiliary carry
  a_r6_incdec_keep_carry: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && (op_e == OP_INC || op_e == OP_DEC))
      |=> (flags_q[FLG_CY] == $past(flags_in[FLG_CY]) &&
           flags_q[FLG_AUX] == $past(flags_in[FLG_AUX])));

  // R10: pair add touches only carry
  a_r10_pair_only_carry: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_e == OP_DAD)
      |=> (wide_we_q && !result_we_q &&
           flags_q[BYTE_W-1:1] == {$past(flags_in[FLG_SGN]), $past(flags_in[FLG_ZER]), 1'b0,
                                   $past(flags_in[FLG_AUX]), 1'b0, $past(flags_in[FLG_PAR]), 1'b1}));

  // R11: idle cycles hold state and drop strobes
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !op_valid |=> (!result_we_q && !wide_we_q && $stable(flags_q) &&
                   $stable(result_q) && $stable(wide_q)));

endmodule

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;
  import byte_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_code;
  logic [7:0]  acc_in, opnd_in, flags_in;
  logic [15:0] pair_a_in, pair_b_in;
  logic [7:0]  result_q;
  logic        result_we_q;
  logic [15:0] wide_q;
  logic        wide_we_q;
  logic [7:0]  flags_q;

  always #2 clk = ~clk;  // 250 MHz

  byte_alu dut_i (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
    .acc_in (acc_in), .opnd_in (opnd_in), .flags_in (flags_in),
    .pair_a_in (pair_a_in), .pair_b_in (pair_b_in),
    .result_q (result_q), .result_we_q (result_we_q), .wide_q (wide_q),
    .wide_we_q (wide_we_q), .flags_q (flags_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0]  e_res  = 8'h00;
  logic        e_we   = 1'b0;
  logic [15:0] e_wide = 16'h0000;
  logic        e_wwe  = 1'b0;
  logic [7:0]  e_flg  = 8'h02;

  function automatic int even_cnt(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return ((c % 2) == 0) ? 1 : 0;
  endfunction

  // behavioural reference
  task automatic model(input int op, input int a, input int b, input int f,
                       input int pa, input int pb);
    int c  = f & 1;
    int ac = (f >> 4) & 1;
    int s  = (f >> 7) & 1;
    int z  = (f >> 6) & 1;
    int p  = (f >> 2) & 1;
    int r  = 0;
    int lo, hi, w;
    bit wr = 0, szp = 0;
    e_wwe = 1'b0;
    case (op)
      0, 1: begin r = a + b + ((op == 1) ? c : 0); c = (r >> 8) & 1; ac = 0; wr = 1; szp = 1; r &= 255; end
      2, 3, 7: begin r = a - b - ((op == 3) ? c : 0); c = (r < 0) ? 1 : 0; ac = 0;
                     wr = (op != 7); szp = 1; r &= 255; end
      4: begin r = a & b; c = 0; ac = 0; wr = 1; szp = 1; end
      5: begin r = a ^ b; c = 0; ac = 0; wr = 1; szp = 1; end
      6: begin r = a | b; c = 0; ac = 0; wr = 1; szp = 1; end
      8: begin r = (b + 1) & 255; wr = 1; szp = 1; end
      9: begin r = (b + 255) & 255; wr = 1; szp = 1; end
      10: begin c = (a >> 7) & 1; r = ((a << 1) | c) & 255; wr = 1; end
      11: begin c = a & 1; r = (a >> 1) | (c << 7); wr = 1; end
      12: begin r = ((a << 1) | c) & 255; c = (a >> 7) & 1; wr = 1; end
      13: begin r = (a >> 1) | (c << 7); c = a & 1; wr = 1; end
      14: begin r = (~a) & 255; wr = 1; end
      15: c = 1;
      16: c = 1 - c;
      17: begin
        r  = a;
        lo = a & 15;
        if (lo > 9 || ac == 1) begin lo += 6; r = (r & 240) | (lo & 15); ac = (lo >> 4) & 1; end
        hi = (r >> 4) & 15;
        if (hi > 9 || ac == 1) begin hi += 6 + ac; r = (r & 15) | ((hi & 15) << 4); end
        c = (hi >> 4) & 1; wr = 1; szp = 1;
      end
      18: begin w = pa + pb; c = (w >> 16) & 1; e_wide = 16'(w & 65535); e_wwe = 1'b1; end
      default: ;
    endcase
    if (szp) begin s = (r >> 7) & 1; z = (r == 0) ? 1 : 0; p = even_cnt(r); end
    if (wr) e_res = 8'(r);
    e_we  = wr;
    e_flg = {1'(s), 1'(z), 1'b0, 1'(ac), 1'b0, 1'(p), 1'b1, 1'(c)};
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (result_q !== e_res || result_we_q !== e_we || wide_q !== e_wide ||
        wide_we_q !== e_wwe || flags_q !== e_flg) begin
      n_bad++;
      $display("FAIL %s: actual res=%h we=%b wide=%h wwe=%b flags=%h expected res=%h we=%b wide=%h wwe=%b flags=%h",
               tag, result_q, result_we_q, wide_q, wide_we_q, flags_q,
               e_res, e_we, e_wide, e_wwe, e_flg);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input bit v, input int op, input int a, input int b, input int f,
                      input int pa, input int pb, input string tag);
    op_valid  = v;
    op_code   = 5'(op);
    acc_in    = 8'(a);
    opnd_in   = 8'(b);
    flags_in  = 8'(f);
    pair_a_in = 16'(pa);
    pair_b_in = 16'(pb);
    if (v) model(op, a, b, f, pa, pb);
    else begin e_we = 1'b0; e_wwe = 1'b0; end
    @(negedge clk);
    check(tag);
  endtask

  function automatic string tag_of(input int op);
    if (op <= 3)  return "R3 R12 arith";
    if (op <= 6)  return "R4 R12 logic";
    if (op == 7)  return "R5 compare";
    if (op <= 9)  return "R6 inc/dec";
    if (op <= 13) return "R7 rotate";
    if (op <= 16) return "R8 cma/carry";
    if (op == 17) return "R9 decimal adjust";
    if (op == 18) return "R10 pair add";
    return "R11 undefined code";
  endfunction

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; acc_in = '0; opnd_in = '0;
    flags_in = '0; pair_a_in = '0; pair_b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset state");

    step(1, 0,  'hFF, 'h01, 'h00, 0, 0, "R3 R12 add wraps to zero");
    step(1, 1,  'h7F, 'h00, 'h01, 0, 0, "R3 adc carry in");
    step(1, 3,  'h10, 'h10, 'h01, 0, 0, "R3 sbb borrow");
    step(1, 2,  'h05, 'h03, 'h00, 0, 0, "R1 R3 back-to-back sub");
    step(1, 7,  'h42, 'h42, 'h00, 0, 0, "R5 compare equal");
    step(1, 7,  'h01, 'h02, 'h00, 0, 0, "R5 compare borrow");
    step(1, 4,  'hF0, 'h3C, 'hFF, 0, 0, "R4 R2 and clears carries");
    step(1, 5,  'hAA, 'hAA, 'h11, 0, 0, "R4 xor to zero");
    step(1, 8,  0,    'hFF, 'h11, 0, 0, "R6 inc wraps keeps carry");
    step(1, 9,  0,    'h00, 'h00, 0, 0, "R6 dec wraps");
    step(1, 10, 'h81, 0,    'h00, 0, 0, "R7 rlc");
    step(1, 11, 'h01, 0,    'h00, 0, 0, "R7 rrc");
    step(1, 12, 'h80, 0,    'h00, 0, 0, "R7 ral");
    step(1, 13, 'h01, 0,    'h01, 0, 0, "R7 rar");
    step(1, 14, 'h5A, 0,    'hD5, 0, 0, "R8 cma keeps flags");
    step(1, 15, 'h00, 0,    'h00, 0, 0, "R8 stc");
    step(1, 16, 'h00, 0,    'hFF, 0, 0, "R8 R2 cmc fixed bits");
    step(1, 17, 'h9B, 0,    'h00, 0, 0, "R9 daa both digits");
    step(1, 17, 'h15, 0,    'h10, 0, 0, "R9 daa aux in");
    step(1, 17, 'hA0, 0,    'h00, 0, 0, "R9 daa high only");
    step(1, 18, 0, 0, 'hC4, 'hFFFF, 'h0001, "R10 pair add carry");
    step(1, 18, 0, 0, 'h01, 'h1234, 'h0100, "R10 pair add no carry");
    step(1, 25, 'h12, 'h34, 'hFF, 0, 0, "R11 undefined code");
    step(0, 0,  'hAA, 'hBB, 'h00, 1, 1, "R11 idle hold");

    for (int k = 0; k < 4000; k++) begin
      int op;
      bit v;
      op = int'($urandom % 24);
      v  = ($urandom % 10) != 0;
      step(v, op, int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
           int'($urandom % 65536), int'($urandom % 65536), v ? tag_of(op) : "R11 idle");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=not finished expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule